// File: doc/BRIEF.md
# USB Root Port Ownership Router

This block sits between four physical downstream root ports and three host controllers: one high-speed controller and two full/low-speed companion controllers. The high-speed controller supplies a global configure flag and one owner bit per port. From these the router decides which controller owns each port. It shows each port's status only to that owner, drives the port's power enable from the owner's power control bit, and discards register writes from the controller that does not own the port.

Companion assignment is fixed and interleaved: even physical indices go to companion 0 and odd ones to companion 1. A static strap selects a two-port root hub, in which the upper two ports are retired. Every reset hands all ports back to the companions. Whenever a port changes hands, its new owner sees a connect-status-change flag, so that its driver enumerates the port again.

Ports use zero-based indices 0..3 (port 1 = index 0). Each status view is a 5-bit word: bit0 connected, bit1 connect-status-change, bit2 overcurrent, bit3 power, bit4 high-speed-only indicator.

Top module: `usb_port_router`

## Requirements
- R1: While reset is held and right after it is released, `hs_owned` is 0, `port_pwr_en` is 0, and every status view and change flag is zero, so all ports belong to the companions.
- R2: Port index p belongs to companion p mod 2 at local slot p/2. Companion c's write selects its local slot with `cc_wr_port[c]`, uses data bits `cc_wr_data[2c+1:2c]` (bit0 power, bit1 write-one-to-clear of the change flag), and reads slot j at `cc_view[(2c+j)*5 +: 5]`.
- R3: A port is owned by the high-speed controller when the configure flag and that port's owner bit are both 1 and the port is in use. `hs_owned` reflects this one clock after the inputs change.
- R4: While `cfg_flag` is 0, every port goes to its companion, whatever the owner bits say.
- R5: A write from a controller that does not own the selected port changes nothing. This applies to the companions and to the high-speed controller alike.
- R6: A controller that does not own a port reads all zeros for that port. Bit4 of a companion view is always 0.
- R7: On the clock edge where ownership of a port changes, the new owner's change flag is set and the old owner's flag is cleared.
- R8: The connected bit follows `phy_conn` one clock later. A change of `phy_conn` sets the owner's change flag. A write of 1 to the clear bit clears the flag, but a new connect change on the same edge wins over the clear.
- R9: `phy_oc_n` is active low. Its inverse shows in bit2 of the owner's view one clock later.
- R10: `port_pwr_en[p]` equals the power bit held by the current owner of the port. `hs_wr_data` bit0 is power, bit1 is the clear of the change flag, and bit2 is the high-speed-only indicator.
- R11: With `two_port` set, ports 2 and 3 are out of use. They are never high-speed owned, their views and power enable stay 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_port | input | 1 | Strap: two-port root hub |
| cfg_flag | input | 1 | Global configure flag from the high-speed controller |
| hs_owner | input | 4 | Per-port owner bits, 1 = high-speed |
| phy_conn | input | 4 | Device present per port |
| phy_oc_n | input | 4 | Overcurrent per port, active low |
| hs_wr_en | input | 1 | High-speed port register write strobe |
| hs_wr_port | input | 2 | High-speed write port index |
| hs_wr_data | input | 3 | High-speed write data |
| cc_wr_en | input | 2 | Companion write strobes |
| cc_wr_port | input | 2 | Companion local slot per companion |
| cc_wr_data | input | 4 | Companion write data, 2 bits per companion |
| hs_view | output | 20 | High-speed status view, 5 bits per port |
| cc_view | output | 20 | Companion status views, 5 bits per slot |
| port_pwr_en | output | 4 | Port power enable |
| hs_owned | output | 4 | Effective high-speed ownership |

## Verification
Ownership, change flags, power bits, the connected bit and the overcurrent bit all pass through one register stage. Each result is therefore due at the first clock edge after the stimulus. The views and power enables are combinational from that stage and from the strap. The bench drives inputs just after a falling edge and steps its reference model once per rising edge. It compares every output at the following falling edge, after the edge that makes the result due and before any new input is applied. Same-edge races (ownership change against a write, connect change against a clear) are covered with directed cases before the random phase.

// File: rtl/usbrt_pkg.sv
package usbrt_pkg;
  localparam int ST_W = 5;

  typedef struct packed {
    logic hs_ext;
    logic power;
    logic overcur;
    logic conn_chg;
    logic connected;
  } port_stat_t;

  // companion controller serving physical port p (interleaved)
  function automatic int comp_of(input int p, input int n_comp);
    return p % n_comp;
  endfunction

  // slot of physical port p inside its companion
  function automatic int slot_of(input int p, input int n_comp);
    return p / n_comp;
  endfunction

  // physical port from companion and slot
  function automatic int phys_of(input int c, input int j, input int n_comp);
    return j * n_comp + c;
  endfunction

  function automatic logic port_in_use(input int p, input logic two_mode, input int two_cnt);
    return (!two_mode) || (p < two_cnt);
  endfunction
endpackage

// File: rtl/usbrt_route_ctl.sv
module usbrt_route_ctl #(
  parameter int N_PORTS = 4,
  parameter int N_COMP  = 2,
  parameter int TWO_CNT = 2,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int LP = N_PORTS / N_COMP,
  localparam int LW = (LP > 1) ? $clog2(LP) : 1
) (
  input  logic                 two_port,
  input  logic                 cfg_flag,
  input  logic [N_PORTS-1:0]   hs_owner,
  input  logic                 hs_wr_en,
  input  logic [PW-1:0]        hs_wr_port,
  input  logic [N_COMP-1:0]    cc_wr_en,
  input  logic [N_COMP*LW-1:0] cc_wr_port,
  input  logic [N_COMP*2-1:0]  cc_wr_data,
  output logic [N_PORTS-1:0]   active,
  output logic [N_PORTS-1:0]   own_req,
  output logic [N_PORTS-1:0]   hs_hit,
  output logic [N_PORTS-1:0]   cc_hit,
  output logic [N_PORTS*2-1:0] cc_data_p
);
  import usbrt_pkg::*;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    localparam int C = comp_of(p, N_COMP);
    localparam int L = slot_of(p, N_COMP);
    assign active[p]  = port_in_use(p, two_port, TWO_CNT);
    assign own_req[p] = cfg_flag & hs_owner[p] & active[p];
    assign hs_hit[p]  = hs_wr_en && (hs_wr_port == PW'(p));
    assign cc_hit[p]  = cc_wr_en[C] && (cc_wr_port[C*LW +: LW] == LW'(L));
    assign cc_data_p[p*2 +: 2] = cc_wr_data[C*2 +: 2];
  end
endmodule

// File: rtl/usbrt_port_slice.sv
module usbrt_port_slice
  import usbrt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            own_req,
  input  logic            phy_conn,
  input  logic            phy_oc_n,
  input  logic            hs_hit,
  input  logic [2:0]      hs_data,
  input  logic            cc_hit,
  input  logic [1:0]      cc_data,
  output logic            own_q,
  output logic [ST_W-1:0] hs_stat,
  output logic [ST_W-1:0] cc_stat,
  output logic            pwr_en
);
  logic conn_q, oc_q, csc_hs, csc_cc, pwr_hs, pwr_cc, ext_bit;
  logic own_chg, conn_evt, hs_acc, cc_acc;
  port_stat_t hs_s, cc_s;

  // named events for the checks below
  assign own_chg  = own_req != own_q;
  assign conn_evt = active && (phy_conn != conn_q);
  assign hs_acc   = hs_hit && own_q && active;
  assign cc_acc   = cc_hit && !own_q && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= 1'b0;
      conn_q  <= 1'b0;
      oc_q    <= 1'b0;
      csc_hs  <= 1'b0;
      csc_cc  <= 1'b0;
      pwr_hs  <= 1'b0;
      pwr_cc  <= 1'b0;
      ext_bit <= 1'b0;
    end else begin
      own_q  <= own_req;
      conn_q <= phy_conn;
      oc_q   <= ~phy_oc_n;
      if (own_chg) begin
        csc_hs <= own_req;
        csc_cc <= ~own_req;
      end else begin
        if (conn_evt && own_q)          csc_hs <= 1'b1;
        else if (hs_acc && hs_data[1])  csc_hs <= 1'b0;
        if (conn_evt && !own_q)         csc_cc <= 1'b1;
        else if (cc_acc && cc_data[1])  csc_cc <= 1'b0;
      end
      if (hs_acc) begin
        pwr_hs  <= hs_data[0];
        ext_bit <= hs_data[2];
      end
      if (cc_acc) pwr_cc <= cc_data[0];
    end
  end

  always_comb begin
    hs_s = '0;
    cc_s = '0;
    if (active && own_q) begin
      hs_s.connected = conn_q;
      hs_s.conn_chg  = csc_hs;
      hs_s.overcur   = oc_q;
      hs_s.power     = pwr_hs;
      hs_s.hs_ext    = ext_bit;
    end
    if (active && !own_q) begin
      cc_s.connected = conn_q;
      cc_s.conn_chg  = csc_cc;
      cc_s.overcur   = oc_q;
      cc_s.power     = pwr_cc;
    end
  end

  assign hs_stat = hs_s;
  assign cc_stat = cc_s;
  assign pwr_en  = active && (own_q ? pwr_hs : pwr_cc);

  assert_cc_write_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_hit && own_q) |=> $stable(pwr_cc));
  assert_hs_write_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_hit && !own_q) |=> ($stable(pwr_hs) && $stable(ext_bit)));
  assert_handover_to_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_q) |-> (csc_hs && !csc_cc));
  assert_handover_to_cc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_q) |-> (csc_cc && !csc_hs));
  assert_unused_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !own_q);
endmodule

// File: rtl/usbrt_view_mux.sv
module usbrt_view_mux #(
  parameter int N_PORTS = 4,
  parameter int N_COMP  = 2,
  localparam int LP = N_PORTS / N_COMP,
  localparam int SW = usbrt_pkg::ST_W
) (
  input  logic [N_PORTS*SW-1:0] cc_stat_p,
  output logic [N_PORTS*SW-1:0] cc_view
);
  import usbrt_pkg::*;

  for (genvar c = 0; c < N_COMP; c++) begin : g_comp
    for (genvar j = 0; j < LP; j++) begin : g_slot
      localparam int P = phys_of(c, j, N_COMP);
      assign cc_view[(c*LP+j)*SW +: SW] = cc_stat_p[P*SW +: SW];
    end
  end
endmodule

// File: rtl/usb_port_router.sv
module usb_port_router #(
  parameter int N_PORTS = 4,
  parameter int N_COMP  = 2,
  parameter int TWO_CNT = 2,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int LP = N_PORTS / N_COMP,
  localparam int LW = (LP > 1) ? $clog2(LP) : 1,
  localparam int SW = usbrt_pkg::ST_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  two_port,
  input  logic                  cfg_flag,
  input  logic [N_PORTS-1:0]    hs_owner,
  input  logic [N_PORTS-1:0]    phy_conn,
  input  logic [N_PORTS-1:0]    phy_oc_n,
  input  logic                  hs_wr_en,
  input  logic [PW-1:0]         hs_wr_port,
  input  logic [2:0]            hs_wr_data,
  input  logic [N_COMP-1:0]     cc_wr_en,
  input  logic [N_COMP*LW-1:0]  cc_wr_port,
  input  logic [N_COMP*2-1:0]   cc_wr_data,
  output logic [N_PORTS*SW-1:0] hs_view,
  output logic [N_PORTS*SW-1:0] cc_view,
  output logic [N_PORTS-1:0]    port_pwr_en,
  output logic [N_PORTS-1:0]    hs_owned
);
  logic [N_PORTS-1:0]    active, own_req, hs_hit, cc_hit;
  logic [N_PORTS*2-1:0]  cc_data_p;
  logic [N_PORTS*SW-1:0] cc_stat_p;

  usbrt_route_ctl #(.N_PORTS(N_PORTS), .N_COMP(N_COMP), .TWO_CNT(TWO_CNT)) u_ctl (
    .two_port   (two_port),
    .cfg_flag   (cfg_flag),
    .hs_owner   (hs_owner),
    .hs_wr_en   (hs_wr_en),
    .hs_wr_port (hs_wr_port),
    .cc_wr_en   (cc_wr_en),
    .cc_wr_port (cc_wr_port),
    .cc_wr_data (cc_wr_data),
    .active     (active),
    .own_req    (own_req),
    .hs_hit     (hs_hit),
    .cc_hit     (cc_hit),
    .cc_data_p  (cc_data_p)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_slice
    usbrt_port_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active[p]),
      .own_req  (own_req[p]),
      .phy_conn (phy_conn[p]),
      .phy_oc_n (phy_oc_n[p]),
      .hs_hit   (hs_hit[p]),
      .hs_data  (hs_wr_data),
      .cc_hit   (cc_hit[p]),
      .cc_data  (cc_data_p[p*2 +: 2]),
      .own_q    (hs_owned[p]),
      .hs_stat  (hs_view[p*SW +: SW]),
      .cc_stat  (cc_stat_p[p*SW +: SW]),
      .pwr_en   (port_pwr_en[p])
    );
  end

  usbrt_view_mux #(.N_PORTS(N_PORTS), .N_COMP(N_COMP)) u_view (
    .cc_stat_p (cc_stat_p),
    .cc_view   (cc_view)
  );

  assert_cfg_off_forces_cc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flag |=> (hs_owned == '0));
endmodule

// File: tb/tb_usb_port_router.sv
module tb_usb_port_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_port = 1'b0, cfg_flag = 1'b0, hs_wr_en = 1'b0;
  logic [3:0] hs_owner = '0, phy_conn = '0, phy_oc_n = 4'hF, cc_wr_data = '0;
  logic [1:0] hs_wr_port = '0, cc_wr_en = '0, cc_wr_port = '0;
  logic [2:0] hs_wr_data = '0;
  logic [19:0] hs_view, cc_view;
  logic [3:0] port_pwr_en, hs_owned;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [3:0] m_own, m_conn, m_oc, m_csch, m_cscc, m_pwh, m_pwc, m_hb;

  always #10 clk = ~clk;

  usb_port_router dut (
    .clk(clk), .rst_n(rst_n), .two_port(two_port), .cfg_flag(cfg_flag),
    .hs_owner(hs_owner), .phy_conn(phy_conn), .phy_oc_n(phy_oc_n),
    .hs_wr_en(hs_wr_en), .hs_wr_port(hs_wr_port), .hs_wr_data(hs_wr_data),
    .cc_wr_en(cc_wr_en), .cc_wr_port(cc_wr_port), .cc_wr_data(cc_wr_data),
    .hs_view(hs_view), .cc_view(cc_view), .port_pwr_en(port_pwr_en), .hs_owned(hs_owned)
  );

  function automatic bit in_use(int p);
    return (p < 2) || !two_port;
  endfunction

  function automatic logic [19:0] exp_hs();
    logic [19:0] v = '0;
    for (int p = 0; p < 4; p++)
      if (in_use(p) && m_own[p])
        v[p*5 +: 5] = {m_hb[p], m_pwh[p], m_oc[p], m_csch[p], m_conn[p]};
    return v;
  endfunction

  function automatic logic [19:0] exp_cc();
    logic [19:0] v = '0;
    for (int c = 0; c < 2; c++)
      for (int j = 0; j < 2; j++) begin
        int p;
        p = c + 2 * j;
        if (in_use(p) && !m_own[p])
          v[(2*c+j)*5 +: 5] = {1'b0, m_pwc[p], m_oc[p], m_cscc[p], m_conn[p]};
      end
    return v;
  endfunction

  function automatic logic [3:0] exp_pwr();
    logic [3:0] v = '0;
    for (int p = 0; p < 4; p++)
      v[p] = in_use(p) && (m_own[p] ? m_pwh[p] : m_pwc[p]);
    return v;
  endfunction

  task automatic model_reset();
    m_own = '0; m_conn = '0; m_oc = '0; m_csch = '0;
    m_cscc = '0; m_pwh = '0; m_pwc = '0; m_hb = '0;
  endtask

  task automatic model_step();
    logic [3:0] n_own = m_own, n_csch = m_csch, n_cscc = m_cscc;
    logic [3:0] n_pwh = m_pwh, n_pwc = m_pwc, n_hb = m_hb;
    for (int p = 0; p < 4; p++) begin
      bit act, req, hacc, cacc, cevt;
      int c, l;
      c = p & 1;
      l = p >> 1;
      act  = in_use(p);
      req  = cfg_flag && hs_owner[p] && act;
      hacc = hs_wr_en && (hs_wr_port == 2'(p)) && m_own[p] && act;
      cacc = cc_wr_en[c] && (cc_wr_port[c] == 1'(l)) && !m_own[p] && act;
      cevt = act && (phy_conn[p] != m_conn[p]);
      n_own[p] = req;
      if (req != m_own[p]) begin
        n_csch[p] = req;
        n_cscc[p] = !req;
      end else begin
        if (cevt && m_own[p]) n_csch[p] = 1'b1;
        else if (hacc && hs_wr_data[1]) n_csch[p] = 1'b0;
        if (cevt && !m_own[p]) n_cscc[p] = 1'b1;
        else if (cacc && cc_wr_data[2*c+1]) n_cscc[p] = 1'b0;
      end
      if (hacc) begin
        n_pwh[p] = hs_wr_data[0];
        n_hb[p] = hs_wr_data[2];
      end
      if (cacc) n_pwc[p] = cc_wr_data[2*c];
    end
    m_own = n_own; m_csch = n_csch; m_cscc = n_cscc;
    m_pwh = n_pwh; m_pwc = n_pwc; m_hb = n_hb;
    m_conn = phy_conn;
    m_oc = ~phy_oc_n;
  endtask

  task automatic check(string tag, string what, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "hs_view", hs_view, exp_hs());
    check(tag, "cc_view", cc_view, exp_cc());
    check(tag, "port_pwr_en", {16'h0, port_pwr_en}, {16'h0, exp_pwr()});
    check(tag, "hs_owned", {16'h0, hs_owned}, {16'h0, m_own});
  endtask

  task automatic idle_writes();
    hs_wr_en = 1'b0;
    cc_wr_en = '0;
  endtask

  task automatic cycle(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
    idle_writes();
  endtask

  task automatic do_reset(bit two);
    rst_n = 1'b0;
    two_port = two;
    cfg_flag = 1'b0; hs_owner = '0; phy_conn = '0; phy_oc_n = 4'hF;
    idle_writes();
    model_reset();
    @(negedge clk);
    @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after reset");
  endtask

  task automatic randomize_inputs();
    if ($urandom % 32 == 0) cfg_flag = ~cfg_flag;
    if ($urandom % 12 == 0) hs_owner = 4'($urandom);
    if ($urandom % 6 == 0) phy_conn[$urandom % 4] ^= 1'b1;
    if ($urandom % 10 == 0) phy_oc_n = 4'($urandom) | 4'($urandom);
    hs_wr_en = ($urandom % 3 == 0);
    hs_wr_port = 2'($urandom);
    hs_wr_data = 3'($urandom);
    cc_wr_en = 2'($urandom);
    cc_wr_port = 2'($urandom);
    cc_wr_data = 4'($urandom);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset(1'b0);
    // R2: companion 1 slot 1 is port 3; companion 0 slot 0 is port 0
    cc_wr_en = 2'b10; cc_wr_port = 2'b10; cc_wr_data = 4'b0100;
    cycle("R2 comp1 slot1 power");
    cc_wr_en = 2'b01; cc_wr_port = 2'b00; cc_wr_data = 4'b0001;
    cycle("R2 comp0 slot0 power");
    cycle("R10 companion power drives enable");
    // R3 and R7: hand ports 0 and 2 to high speed
    phy_conn = 4'b0001;
    cycle("R8 connect under companion");
    cfg_flag = 1'b1; hs_owner = 4'b0101;
    cycle("R3 and R7 hand over to high speed");
    // R5: companion write to high-speed owned port 0 is dropped
    cc_wr_en = 2'b01; cc_wr_port = 2'b00; cc_wr_data = 4'b0000;
    cycle("R5 companion write dropped");
    hs_wr_en = 1'b1; hs_wr_port = 2'd1; hs_wr_data = 3'b101;
    cycle("R5 high-speed write dropped");
    hs_wr_en = 1'b1; hs_wr_port = 2'd0; hs_wr_data = 3'b101;
    cycle("R10 R6 high-speed power and indicator");
    // R8: clear flag, then a connect change racing a clear
    hs_wr_en = 1'b1; hs_wr_port = 2'd0; hs_wr_data = 3'b011;
    cycle("R8 write-one clear");
    phy_conn[0] = 1'b0;
    hs_wr_en = 1'b1; hs_wr_port = 2'd0; hs_wr_data = 3'b011;
    cycle("R8 set beats clear");
    phy_oc_n = 4'b1110;
    cycle("R9 overcurrent active low");
    phy_oc_n = 4'hF;
    cycle("R9 overcurrent released");
    cfg_flag = 1'b0;
    cycle("R4 configure flag off");
    cycle("R7 companion regains flag");
    // R11: two-port strap
    do_reset(1'b1);
    cfg_flag = 1'b1; hs_owner = 4'hF; phy_conn = 4'hF;
    cc_wr_en = 2'b11; cc_wr_port = 2'b11; cc_wr_data = 4'b0101;
    cycle("R11 upper ports unused");
    hs_wr_en = 1'b1; hs_wr_port = 2'd3; hs_wr_data = 3'b101;
    cycle("R11 write to unused port");
    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      cycle("R11 random two-port");
    end
    do_reset(1'b0);
    for (int i = 0; i < 6000; i++) begin
      randomize_inputs();
      cycle("R6 random four-port");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule